// File: doc/BRIEF.md
# Octet-Parallel ATM Cell Delineation Engine

This block finds the boundaries of fixed-size 53-octet cells in a byte stream whose bit alignment is unknown. Octets arrive one per clock, most significant bit first. On every accepted octet the block works out the remainder, modulo x^8 + x^2 + x + 1, of each of the eight 40-bit windows that end inside that octet. The 40 bits are 32 header bits followed by the header check byte. A window whose remainder equals the coset value 0x55 is a header candidate, and the block reports it as one bit per offset.

A lock machine watches these candidates. In the hunting state it takes the first candidate it sees. It then confirms that the same bit offset holds a valid header every 53 octets. After enough confirmations it declares sync. Once in sync it gives up only after a run of failed headers. The locked bit offset, a sync flag and a one-cycle strobe at each expected header position are the block's outputs. A framer, a header corrector or a payload descrambler placed downstream uses them.

Top module: `celldelin_top`

## Requirements
- R1: One cycle after an octet is accepted (`in_vld` high), `hec_ok[k]` is 1 exactly when the 40 most recent stream bits that end with bit k+1 of that octet leave a remainder of 0x55 modulo x^8 + x^2 + x + 1. Bits arrive most significant bit first, so bit 1 of the octet is `in_octet[7]`. In the window, the oldest bit is the coefficient of the highest degree. Bits before the first octet after reset count as zero.
- R2: `ok_vld` is `in_vld` delayed by one cycle. While `ok_vld` is low, `hec_ok` is all zero and the lock machine does not advance.
- R3: After reset `lock_state` is 0 (hunting), `sync`, `cell_strobe` and `ok_vld` are 0, and `hec_ok` is zero.
- R4: In the hunting state, any set bit of `hec_ok` moves the machine to the pre-sync state (`lock_state` 1). `lock_ofs` takes the lowest set index.
- R5: Once locked, the offset bit `hec_ok[lock_ofs]` is examined on every 53rd accepted octet after the lock octet. In pre-sync, six consecutive hits enter sync (`lock_state` 2). A single miss returns the machine to hunting.
- R6: In sync, seven consecutive misses at the examined positions return the machine to hunting. A hit clears the run, so six misses followed by a hit keep sync.
- R7: `cell_strobe` is a one-cycle pulse, issued one cycle after each examined position that is evaluated while in sync, and at no other time.
- R8: `lock_ofs` does not change while the machine stays out of the hunting state.
- R9: For a stream of correctly coded cells delayed by s bits, the block settles at `lock_ofs` = (s + 7) mod 8 with `sync` high.
- R10: `lock_state` only takes the values 0, 1 and 2, and `sync` is high exactly in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Octet strobe |
| in_octet | input | 8 | Stream octet, bit 7 received first |
| hec_ok | output | 8 | Per-offset header match for the last accepted octet |
| ok_vld | output | 1 | `hec_ok` qualifies an accepted octet |
| lock_state | output | 2 | 0 hunting, 1 pre-sync, 2 sync |
| lock_ofs | output | 3 | Locked bit offset within the octet |
| sync | output | 1 | High while in sync |
| cell_strobe | output | 1 | Pulse at each expected header position while in sync |

## Verification
The hardest situation to reach from the ports is a clean lock at every one of the eight bit offsets. Random payload can put false header candidates ahead of the real one, and a lock on such a candidate would shift the whole acquisition. The stimulus therefore builds a bit stream of whole cells, pads it with a variable number of zero bits, and gives the first cell an all-zero header. With that choice no window can match before the true header ends, so the cell at which sync rises is known exactly for each shift. A second stream then corrupts the check byte of runs of six and seven consecutive cells, which drives the sync-loss counter to its limit and one step short of it.

// File: rtl/celldelin_pkg.sv
package celldelin_pkg;

  localparam int OCT_BITS = 8;
  localparam logic [7:0] GEN_LOW = 8'h07;  // x^2 + x + 1, x^8 implied
  localparam logic [7:0] COSET_REM = 8'h55;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2
  } lock_st_e;

  // multiply a remainder by x, reduced by the generator
  function automatic logic [7:0] mul_x(input logic [7:0] r);
    return r[7] ? ({r[6:0], 1'b0} ^ GEN_LOW) : {r[6:0], 1'b0};
  endfunction

  // x^n reduced by the generator
  function automatic logic [7:0] x_pow(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < n; i++) r = mul_x(r);
    return r;
  endfunction

  // shift one bit into the window and cancel the bit that leaves it
  function automatic logic [7:0] slide_fwd(input logic [7:0] r, input logic b_in,
                                           input logic b_out, input logic [7:0] drop);
    return mul_x(r) ^ {7'd0, b_in} ^ (b_out ? drop : 8'h00);
  endfunction

  // undo one forward slide: restore the leaving bit, then divide by x
  function automatic logic [7:0] slide_bwd(input logic [7:0] r, input logic b_in,
                                           input logic b_out, input logic [7:0] drop);
    logic [7:0] t;
    logic [7:0] u;
    t = r ^ {7'd0, b_in} ^ (b_out ? drop : 8'h00);
    u = t ^ GEN_LOW;
    return t[0] ? {1'b1, u[7:1]} : {1'b0, t[7:1]};
  endfunction

  function automatic logic [2:0] lowest_set(input logic [7:0] v);
    logic [2:0] idx;
    idx = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) idx = 3'(i);
    return idx;
  endfunction

endpackage

// File: rtl/celldelin_window.sv
module celldelin_window
  import celldelin_pkg::*;
#(
  parameter int WIN_BITS = 40,
  parameter int FWD_TAPS = 4,
  parameter logic [7:0] MATCH_REM = COSET_REM
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [7:0] in_octet,
  output logic [7:0] hec_ok,
  output logic       ok_vld
);

  localparam int SEQ_BITS = WIN_BITS + OCT_BITS;
  localparam logic [7:0] DROP_TERM = x_pow(WIN_BITS);

  logic [WIN_BITS-1:0] hist_q;
  logic [7:0]          bnd_rem_q;
  logic [SEQ_BITS-1:0] seq;
  logic [7:0]          rem [OCT_BITS];
  logic [7:0]          hit;

  assign seq = {hist_q, in_octet};

  // forward taps from the old boundary remainder, backward taps from the new one
  always_comb begin
    logic [7:0] cur;
    logic [7:0] back;
    for (int k = 0; k < OCT_BITS; k++) rem[k] = 8'h00;
    cur = bnd_rem_q;
    for (int i = 0; i < OCT_BITS; i++) begin
      cur = slide_fwd(cur, seq[OCT_BITS-1-i], seq[SEQ_BITS-1-i], DROP_TERM);
      if (i < FWD_TAPS) rem[i] = cur;
    end
    rem[OCT_BITS-1] = cur;
    back = cur;
    for (int k = OCT_BITS - 2; k >= FWD_TAPS; k--) begin
      back = slide_bwd(back, seq[OCT_BITS-2-k], seq[SEQ_BITS-2-k], DROP_TERM);
      rem[k] = back;
    end
  end

  always_comb begin
    for (int k = 0; k < OCT_BITS; k++) hit[k] = (rem[k] == MATCH_REM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      bnd_rem_q <= 8'h00;
      hec_ok    <= 8'h00;
      ok_vld    <= 1'b0;
    end else begin
      ok_vld <= in_vld;
      hec_ok <= in_vld ? hit : 8'h00;
      if (in_vld) begin
        hist_q    <= seq[WIN_BITS-1:0];
        bnd_rem_q <= rem[OCT_BITS-1];
      end
    end
  end

endmodule

// File: rtl/celldelin_lock.sv
module celldelin_lock
  import celldelin_pkg::*;
#(
  parameter int CELL_OCTETS = 53,
  parameter int CONFIRM_RUN = 6,
  parameter int MISS_RUN    = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ok_vld,
  input  logic [7:0] hec_ok,
  output lock_st_e   state,
  output logic [2:0] ofs,
  output logic       strobe,
  output logic       ev_expect,
  output logic       ev_hit
);

  localparam int POS_W = $clog2(CELL_OCTETS);
  localparam int RUN_MAX = (CONFIRM_RUN > MISS_RUN) ? CONFIRM_RUN : MISS_RUN;
  localparam int RUN_W = $clog2(RUN_MAX + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELL_OCTETS - 1);
  localparam logic [RUN_W-1:0] CONF_LAST = RUN_W'(CONFIRM_RUN - 1);
  localparam logic [RUN_W-1:0] MISS_LAST = RUN_W'(MISS_RUN - 1);

  logic [POS_W-1:0] pos_q;
  logic [RUN_W-1:0] run_q;

  assign ev_expect = ok_vld && (state != ST_HUNT) && (pos_q == POS_LAST);
  assign ev_hit    = hec_ok[ofs];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HUNT;
      ofs    <= 3'd0;
      pos_q  <= '0;
      run_q  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (ok_vld) begin
        if (state == ST_HUNT) begin
          if (|hec_ok) begin
            state <= ST_PRE;
            ofs   <= lowest_set(hec_ok);
            pos_q <= '0;
            run_q <= '0;
          end
        end else begin
          pos_q <= ev_expect ? '0 : pos_q + 1'b1;
          if (ev_expect) begin
            if (state == ST_PRE) begin
              if (!ev_hit) begin
                state <= ST_HUNT;
              end else if (run_q == CONF_LAST) begin
                state <= ST_SYNC;
                run_q <= '0;
              end else begin
                run_q <= run_q + 1'b1;
              end
            end else begin
              strobe <= 1'b1;
              if (ev_hit) begin
                run_q <= '0;
              end else if (run_q == MISS_LAST) begin
                state <= ST_HUNT;
              end else begin
                run_q <= run_q + 1'b1;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/celldelin_top.sv
module celldelin_top
  import celldelin_pkg::*;
#(
  parameter int WIN_BITS    = 40,
  parameter int FWD_TAPS    = 4,
  parameter int CELL_OCTETS = 53,
  parameter int CONFIRM_RUN = 6,
  parameter int MISS_RUN    = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [7:0] in_octet,
  output logic [7:0] hec_ok,
  output logic       ok_vld,
  output logic [1:0] lock_state,
  output logic [2:0] lock_ofs,
  output logic       sync,
  output logic       cell_strobe
);

  lock_st_e st;
  logic     ev_expect;
  logic     ev_hit;

  celldelin_window #(
    .WIN_BITS (WIN_BITS),
    .FWD_TAPS (FWD_TAPS),
    .MATCH_REM(COSET_REM)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_octet(in_octet),
    .hec_ok  (hec_ok),
    .ok_vld  (ok_vld)
  );

  celldelin_lock #(
    .CELL_OCTETS(CELL_OCTETS),
    .CONFIRM_RUN(CONFIRM_RUN),
    .MISS_RUN   (MISS_RUN)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .ok_vld   (ok_vld),
    .hec_ok   (hec_ok),
    .state    (st),
    .ofs      (lock_ofs),
    .strobe   (cell_strobe),
    .ev_expect(ev_expect),
    .ev_hit   (ev_hit)
  );

  assign lock_state = st;
  assign sync       = (st == ST_SYNC);

endmodule

// File: rtl/celldelin_chk.sv
module celldelin_chk
  import celldelin_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_vld,
  input logic       ok_vld,
  input logic [7:0] hec_ok,
  input logic [1:0] lock_state,
  input logic [2:0] lock_ofs,
  input logic       sync,
  input logic       cell_strobe,
  input logic       ev_expect,
  input logic       ev_hit
);

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ok_vld); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ok_vld |-> (hec_ok == 8'h00)); // R2

  AST_HUNT_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (lock_state == ST_HUNT && ok_vld && (hec_ok != 8'h00)) |=>
      (lock_state == ST_PRE) && ((($past(hec_ok) >> lock_ofs) & 8'd1) == 8'd1) &&
      (($past(hec_ok) & ((8'd1 << lock_ofs) - 8'd1)) == 8'h00)); // R4

  AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (lock_state == ST_SYNC && $past(lock_state) != ST_SYNC) |->
      ($past(lock_state) == ST_PRE && $past(ev_expect) && $past(ev_hit))); // R5

  AST_PRE_MISS: assert property (@(posedge clk) disable iff (rst)
    (lock_state == ST_PRE && ev_expect && !ev_hit) |=> (lock_state == ST_HUNT)); // R5

  AST_SYNC_HIT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (lock_state == ST_SYNC && ev_expect && ev_hit) |=> (lock_state == ST_SYNC)); // R6

  AST_STROBE_DUE: assert property (@(posedge clk) disable iff (rst)
    (lock_state == ST_SYNC && ev_expect) |=> cell_strobe); // R7

  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
    cell_strobe |-> ($past(lock_state) == ST_SYNC && $past(ev_expect))); // R7

  AST_OFS_HELD: assert property (@(posedge clk) disable iff (rst)
    (lock_state != ST_HUNT && $past(lock_state) != ST_HUNT) |-> $stable(lock_ofs)); // R8

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (lock_state != 2'd3) && (sync == (lock_state == ST_SYNC))); // R10

endmodule

bind celldelin_top celldelin_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_vld     (in_vld),
  .ok_vld     (ok_vld),
  .hec_ok     (hec_ok),
  .lock_state (lock_state),
  .lock_ofs   (lock_ofs),
  .sync       (sync),
  .cell_strobe(cell_strobe),
  .ev_expect  (ev_expect),
  .ev_hit     (ev_hit)
);

// File: tb/tb_celldelin_top.sv
module tb_celldelin_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_vld;
  logic [7:0] in_octet;
  logic [7:0] hec_ok;
  logic       ok_vld;
  logic [1:0] lock_state;
  logic [2:0] lock_ofs;
  logic       sync;
  logic       cell_strobe;

  always #10 clk = ~clk;  // 50 MHz

  celldelin_top dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_octet(in_octet),
    .hec_ok(hec_ok), .ok_vld(ok_vld), .lock_state(lock_state),
    .lock_ofs(lock_ofs), .sync(sync), .cell_strobe(cell_strobe)
  );

  int total = 0;
  int bad = 0;
  int nbits;
  int nstrobe;
  bit count_strobe = 1'b0;
  bit sbits [16384];
  int sync_at [32];
  int state_at [32];
  int ofs_at [32];
  logic [31:0] rs = 32'h1234_5678;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] div_rem(input logic [39:0] w);
    logic [39:0] v;
    v = w;
    for (int i = 39; i >= 8; i--) if (v[i]) v[i-:9] = v[i-:9] ^ 9'h107;
    return v[7:0];
  endfunction

  function automatic logic [7:0] rnd_byte();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[7:0];
  endfunction

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sbits[nbits] = b[i];
      nbits++;
    end
  endtask

  task automatic build(input int shift, input int ncell, input logic [31:0] badmask);
    logic [31:0] h;
    logic [7:0]  hc;
    nbits = 0;
    for (int i = 0; i < shift; i++) begin
      sbits[nbits] = 1'b0;
      nbits++;
    end
    for (int c = 0; c < ncell; c++) begin
      h = (c == 0) ? 32'h0 : {rnd_byte(), rnd_byte(), rnd_byte(), rnd_byte()};
      hc = div_rem({h, 8'h00}) ^ 8'h55;
      if (badmask[c]) hc = hc ^ 8'h01;
      for (int j = 3; j >= 0; j--) put_byte(h[8*j +: 8]);
      put_byte(hc);
      for (int j = 0; j < 48; j++) put_byte(rnd_byte());
    end
    while (nbits % 8 != 0) begin
      sbits[nbits] = 1'b0;
      nbits++;
    end
  endtask

  function automatic logic [7:0] expect_hits(input int m);
    logic [7:0]  r;
    logic [39:0] w;
    int e;
    int p;
    r = 8'h00;
    for (int k = 0; k < 8; k++) begin
      e = 8 * m + k;
      for (int j = 0; j < 40; j++) begin
        p = e - 39 + j;
        w[39-j] = (p < 0) ? 1'b0 : sbits[p];
      end
      r[k] = (div_rem(w) == 8'h55);
    end
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    in_vld = 1'b0;
    in_octet = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(lock_state == 2'd0 && !sync && !cell_strobe && !ok_vld && hec_ok == 8'h00,
          "R3 reset state", {lock_state, sync, cell_strobe, ok_vld}, 0);
  endtask

  task automatic run_stream(input int shift, input int ncell);
    logic [7:0] b;
    logic [7:0] ex;
    for (int m = 0; m < nbits / 8; m++) begin
      if (m % 17 == 16) begin
        in_vld = 1'b0;
        @(negedge clk);
        check(!ok_vld && hec_ok == 8'h00, "R2 idle octet", {ok_vld, hec_ok}, 0);
      end
      for (int i = 0; i < 8; i++) b[7-i] = sbits[8*m + i];
      in_vld = 1'b1;
      in_octet = b;
      @(negedge clk);
      ex = expect_hits(m);
      check(ok_vld && hec_ok == ex, "R1 per-offset match", {ok_vld, hec_ok}, {1'b1, ex});
      for (int c = 0; c < ncell; c++) begin
        if (m == (shift + 424 * c + 39) / 8 + 3) begin
          sync_at[c]  = sync;
          state_at[c] = lock_state;
          ofs_at[c]   = lock_ofs;
        end
      end
    end
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) if (count_strobe && cell_strobe) nstrobe++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int want;
    for (int s = 0; s < 8; s++) begin
      do_reset();
      build(s, 10, 32'h0);
      nstrobe = 0;
      count_strobe = 1'b1;
      run_stream(s, 10);
      count_strobe = 1'b0;
      want = (s + 7) % 8;
      check(state_at[0] == 1 && ofs_at[0] == want, "R4 first hit to pre-sync", ofs_at[0], want);
      check(sync_at[5] == 0 && state_at[5] == 1, "R5 five confirmations not enough", state_at[5], 1);
      check(sync_at[6] == 1 && state_at[6] == 2, "R5 sixth confirmation enters sync", state_at[6], 2);
      for (int c = 1; c < 10; c++)
        check(ofs_at[c] == want, "R8 offset held", ofs_at[c], want);
      check(sync && lock_ofs == want, "R9 lock offset for shift", lock_ofs, want);
      check(nstrobe == 3, "R7 strobe count", nstrobe, 3);
      check(sync == (lock_state == 2'd2), "R10 sync flag", sync, lock_state);
    end

    // error runs: six misses then a hit, then seven misses
    do_reset();
    build(5, 26, 32'h00FE_FC00);
    nstrobe = 0;
    count_strobe = 1'b1;
    run_stream(5, 26);
    count_strobe = 1'b0;
    check(sync_at[9] == 1, "R9 sync before errors", sync_at[9], 1);
    check(sync_at[15] == 1, "R6 six misses keep sync", sync_at[15], 1);
    check(sync_at[16] == 1, "R6 hit after six misses", sync_at[16], 1);
    check(sync_at[22] == 1, "R6 six misses of second run", sync_at[22], 1);
    check(sync_at[23] == 0 && state_at[23] != 2, "R6 seventh miss loses sync", state_at[23], 0);
    check(nstrobe == 17, "R7 strobes up to loss", nstrobe, 17);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule